// File: doc/BRIEF.md
# Temperature Display Pipeline

This block turns an 8-bit temperature reading, already scaled so that its binary value equals degrees Fahrenheit, into a two-digit seven-segment readout plus a pair of indicator LEDs. A display register holds the reading that is shown. It takes a new value only on the rising edge of a slow (nominally 1 Hz) tick, and it refuses that value whenever the upstream capture logic reports that the reading is being updated. The tick arrives as a level on an input and is edge-detected in the block's clock domain.

The held reading is zero-extended to a 9-bit operand. An unrolled network of conditional add-three cells converts it into hundreds, tens and units decimal digits. The network shifts the operand left across an empty decimal field one bit per input bit. After each shift except the last, it raises any digit above four by three. No test is made until three bits have been shifted in. The tens and units digits each feed a seven-segment decoder. The two low bits of the hundreds digit drive the LEDs. The outputs are combinational from the display register, so a new reading is visible in the same clock period in which it is loaded.

Top module: `temp_display_top`

## Requirements
- R1: On a clock edge where `tick_1hz` is high, it was low at the previous edge, and `capture_busy` is low, the display register takes `temp_byte`. The outputs show the new value right after that edge.
- R2: On a clock edge where `capture_busy` is high, the display register keeps its value even if the tick rises. No load is retried later for that tick.
- R3: The display register keeps its value on every edge where the tick is low, and on every edge where the tick was already high at the previous edge.
- R4: The conversion network gives the correct decimal digits for every 9-bit input 0 to 511. For example, binary 101100101 gives hundreds 3, tens 5, units 7.
- R5: The 8-bit reading is zero-extended before conversion, so a reading of 255 shows hundreds 2, tens 5, units 5.
- R6: Segment outputs are active high, with bit 0 = segment a through bit 6 = segment g. Digits 0..9 give the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. Codes 10..15 give 0x00.
- R7: `hund_led[1]` and `hund_led[0]` are bits 1 and 0 of the hundreds digit.
- R8: After reset the display register is zero: both digits show 0x3F and both LEDs are off.
- R9: Readings below 10 show a lit zero (0x3F) in the tens position, not a blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | Slow display-update tick, level; its rising edge requests a load |
| capture_busy | input | 1 | High while the upstream reading is changing; inhibits the load |
| temp_byte | input | 8 | Captured reading, numerically degrees Fahrenheit |
| seg_units | output | 7 | Units digit segments, bit 0 = a .. bit 6 = g, active high |
| seg_tens | output | 7 | Tens digit segments, bit 0 = a .. bit 6 = g, active high |
| hund_led | output | 2 | Low two bits of the hundreds digit |

## Verification
The display register is the only state, and every output is decoded from it with no further registers. A wrong load decision shows up at the segment and LED pins in the same clock period, directly after the edge that made it. A missed load leaves the old digits on the pins. A spurious load, one taken while busy or on a held tick, shows a changed reading one edge early. A fault in one add-three cell affects only the readings whose carry path passes through that cell. Because of that, the conversion network is also driven on its own over its whole 9-bit range, and every reading from 0 to 255 is loaded through the ports.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  // Conditional correction applied to one decimal digit between shifts.
  function automatic bcd_t add3_if_big(input bcd_t d);
    return (d > 4'd4) ? bcd_t'(d + 4'd3) : d;
  endfunction

  // Active-high segments, bit 0 = a ... bit 6 = g; non-decimal codes blank.
  function automatic seg_t seg_pattern(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tdisp_add3.sv
module tdisp_add3
  import tdisp_pkg::*;
(
  input  bcd_t din,
  output bcd_t dout
);
  assign dout = add3_if_big(din);
endmodule

// File: rtl/tdisp_bcd_net.sv
module tdisp_bcd_net #(
  parameter int BIN_W   = 9,
  parameter int NUM_DIG = 3
) (
  input  logic [BIN_W-1:0]     bin,
  output logic [4*NUM_DIG-1:0] bcd
);
  localparam int BCD_W     = 4 * NUM_DIG;
  localparam int TOT_W     = BIN_W + BCD_W;
  localparam int FIRST_TST = 3;

  logic [TOT_W-1:0] stage [0:BIN_W];

  assign stage[0] = {{BCD_W{1'b0}}, bin};

  for (genvar k = 1; k <= BIN_W; k++) begin : g_step
    logic [TOT_W-1:0] shifted;
    logic [TOT_W-1:0] nxt;
    assign shifted = {stage[k-1][TOT_W-2:0], 1'b0};
    if (k >= FIRST_TST && k < BIN_W) begin : g_test
      assign nxt[BIN_W-1:0] = shifted[BIN_W-1:0];
      for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
        tdisp_add3 u_cell (
          .din  (shifted[BIN_W+4*d +: 4]),
          .dout (nxt[BIN_W+4*d +: 4])
        );
      end
    end else begin : g_pass
      assign nxt = shifted;
    end
    assign stage[k] = nxt;
  end

  assign bcd = stage[BIN_W][TOT_W-1 -: BCD_W];

  logic unused_low;
  assign unused_low = ^stage[BIN_W][BIN_W-1:0];
endmodule

// File: rtl/tdisp_seg7.sv
module tdisp_seg7
  import tdisp_pkg::*;
(
  input  bcd_t digit,
  output seg_t seg
);
  assign seg = seg_pattern(digit);
endmodule

// File: rtl/tdisp_load_reg.sv
module tdisp_load_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              busy,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              tick_prev,
  output logic              load_fire
);
  logic tick_rise;

  assign tick_rise = tick & ~tick_prev;
  assign load_fire = tick_rise & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_prev <= 1'b0;
      dout      <= '0;
    end else begin
      tick_prev <= tick;
      if (load_fire) dout <= din;
    end
  end
endmodule

// File: rtl/temp_display_top.sv
module temp_display_top
  import tdisp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CONV_W  = 9,
  parameter int NUM_DIG = 3,
  parameter int LED_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              capture_busy,
  input  logic [DATA_W-1:0] temp_byte,
  output logic [6:0]        seg_units,
  output logic [6:0]        seg_tens,
  output logic [LED_W-1:0]  hund_led
);
  localparam int PAD_W = CONV_W - DATA_W;

  logic [DATA_W-1:0]    disp_q;
  logic                 tick_prev;
  logic                 load_fire;
  logic [CONV_W-1:0]    conv_in;
  logic [4*NUM_DIG-1:0] bcd_all;
  bcd_t                 units_d, tens_d, hund_d;

  tdisp_load_reg #(.DATA_W(DATA_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .busy      (capture_busy),
    .din       (temp_byte),
    .dout      (disp_q),
    .tick_prev (tick_prev),
    .load_fire (load_fire)
  );

  assign conv_in = {{PAD_W{1'b0}}, disp_q};

  tdisp_bcd_net #(.BIN_W(CONV_W), .NUM_DIG(NUM_DIG)) u_conv (
    .bin (conv_in),
    .bcd (bcd_all)
  );

  assign units_d = bcd_all[3:0];
  assign tens_d  = bcd_all[7:4];
  assign hund_d  = bcd_all[11:8];

  tdisp_seg7 u_seg_u (.digit(units_d), .seg(seg_units));
  tdisp_seg7 u_seg_t (.digit(tens_d),  .seg(seg_tens));

  assign hund_led = hund_d[LED_W-1:0];

  logic unused_hi;
  assign unused_hi = ^{hund_d[3:LED_W], load_fire};
endmodule

// File: rtl/temp_display_chk.sv
module temp_display_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              capture_busy,
  input logic [DATA_W-1:0] temp_byte,
  input logic [DATA_W-1:0] disp_q,
  input logic              tick_prev,
  input logic [3:0]        units_d,
  input logic [3:0]        tens_d,
  input logic [3:0]        hund_d,
  input logic [6:0]        seg_units,
  input logic [6:0]        seg_tens
);
  // R1
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !tick_prev && !capture_busy) |=> (disp_q == $past(temp_byte)));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_busy |=> $stable(disp_q));

  // R3
  low_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1hz |=> $stable(disp_q));

  // R3
  held_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_prev |=> $stable(disp_q));

  // R4
  digit_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hund_d) * 100 + int'(tens_d) * 10 + int'(units_d)) == int'(disp_q));

  // R5
  hund_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hund_d <= 4'd2);

  // R6
  digits_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_units != 7'h00) && (seg_tens != 7'h00));
endmodule

bind temp_display_top temp_display_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_1hz     (tick_1hz),
  .capture_busy (capture_busy),
  .temp_byte    (temp_byte),
  .disp_q       (disp_q),
  .tick_prev    (tick_prev),
  .units_d      (units_d),
  .tens_d       (tens_d),
  .hund_d       (hund_d),
  .seg_units    (seg_units),
  .seg_tens     (seg_tens)
);

// File: tb/sim_temp_display_top.sv
module sim_temp_display_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       capture_busy = 1'b0;
  logic [7:0] temp_byte = 8'hA5;
  logic [6:0] seg_units, seg_tens;
  logic [1:0] hund_led;

  logic [8:0]  net_in = '0;
  logic [11:0] net_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_display_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .capture_busy(capture_busy),
    .temp_byte(temp_byte), .seg_units(seg_units), .seg_tens(seg_tens), .hund_led(hund_led)
  );

  tdisp_bcd_net #(.BIN_W(9), .NUM_DIG(3)) u_net (.bin(net_in), .bcd(net_out));

  function automatic logic [6:0] exp_seg(input int d);
    logic [6:0] s;
    case (d)
      0: s = 7'h3F; 1: s = 7'h06; 2: s = 7'h5B; 3: s = 7'h4F; 4: s = 7'h66;
      5: s = 7'h6D; 6: s = 7'h7D; 7: s = 7'h07; 8: s = 7'h7F; 9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_display(input int v, input string req);
    int h, t, u;
    h = v / 100; t = (v / 10) % 10; u = v % 10;
    check(seg_tens == exp_seg(t), {req, " tens"}, seg_tens, exp_seg(t));
    check(seg_units == exp_seg(u), {req, " units"}, seg_units, exp_seg(u));
    check(hund_led == 2'(h), {req, " leds"}, hund_led, h % 4);
  endtask

  task automatic pulse_load(input logic [7:0] v);
    @(negedge clk);
    temp_byte = v;
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_display(0, "R8 during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_display(0, "R8 after reset, tick idle");
  endtask

  task automatic t_basic();
    pulse_load(8'd72);  check_display(72, "R1 load 72");
    pulse_load(8'd7);   check_display(7, "R9 single digit");
    pulse_load(8'd255); check_display(255, "R5 max reading");
    check(hund_led == 2'b10, "R7 led bits for 255", hund_led, 2);
    pulse_load(8'd100); check_display(100, "R7 hundreds one");
    pulse_load(8'd0);   check_display(0, "R1 load zero");
  endtask

  task automatic t_held();
    pulse_load(8'd40);
    @(negedge clk); temp_byte = 8'd41; tick_1hz = 1'b1;
    @(negedge clk); check_display(41, "R1 rising edge");
    temp_byte = 8'd99;
    repeat (3) @(negedge clk);
    check_display(41, "R3 tick held high");
    tick_1hz = 1'b0;
    temp_byte = 8'd77;
    repeat (3) @(negedge clk);
    check_display(41, "R3 tick low");
  endtask

  task automatic t_busy();
    @(negedge clk); capture_busy = 1'b1; temp_byte = 8'd88; tick_1hz = 1'b1;
    @(negedge clk); check_display(41, "R2 busy at rising edge");
    capture_busy = 1'b0;
    repeat (2) @(negedge clk);
    check_display(41, "R2 no late retry");
    tick_1hz = 1'b0;
    pulse_load(8'd88);
    check_display(88, "R2 next tick loads");
  endtask

  task automatic t_sweep();
    int bad = 0;
    for (int v = 0; v < 256; v++) begin
      pulse_load(8'(v));
      if (seg_tens != exp_seg((v / 10) % 10) || seg_units != exp_seg(v % 10) ||
          hund_led != 2'(v / 100)) begin
        bad++;
        if (bad < 4) check(1'b0, "R6 sweep", v, v);
      end
    end
    check(bad == 0, "R6 sweep all readings", bad, 0);
  endtask

  task automatic t_net();
    int bad = 0;
    int exp;
    net_in = 9'b101100101;
    #1;
    check(net_out == 12'h357, "R4 network 357", net_out, 12'h357);
    for (int v = 0; v < 512; v++) begin
      net_in = 9'(v);
      #1;
      exp = ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
      if (int'(net_out) != exp) begin
        bad++;
        if (bad < 4) check(1'b0, "R4 network sweep", net_out, exp);
      end
    end
    check(bad == 0, "R4 network all inputs", bad, 0);
  endtask

  initial begin
    t_reset();
    t_net();
    t_basic();
    t_held();
    t_busy();
    t_sweep();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule